// File: doc/BRIEF.md
# Split-Storage Reservation Station Array

This block is the waiting window of an out-of-order core. Dispatched instructions are written into free slots together with the tags of their two source operands. Each source is either already present at dispatch or still outstanding. Every cycle the array compares the outstanding tags against all result broadcast buses. A matching broadcast marks that operand as present in the same cycle and captures its value.

Each slot keeps its bookkeeping (occupied, operand-present and ready flags, tags, age relation) in fast single-cycle flops. The operand values go into a slow store, where every write takes `WR_LAT` cycles to complete. A slot is offered to the issue selector only when both operands are present and both of its value writes have completed. The selector then picks up to `ISS_W` slots per cycle, oldest first, and hands out their ID and operand values. An issued slot is free for dispatch from the next cycle on. When a cycle brings more dispatch requests than there are free slots, the whole group is refused.

Top module: `rsw_window`

## Requirements
- R1: After reset no slot is occupied, `iss_valid` is all zero and `disp_stall` is low.
- R2: Any subset of the `DISP_W` dispatch lanes may be valid in a cycle, sparse subsets included, and every valid lane takes its own free slot. Within one cycle, a lower-numbered lane counts as older than a higher-numbered one.
- R3: An outstanding operand becomes present when any result bus carries its tag with `res_valid` set, and its value is taken from that bus. This also applies in the cycle in which the instruction is dispatched.
- R4: A slot's ready flag is set exactly when both of its operands are present. An instruction with an outstanding operand is never issued, even after a broadcast whose tag does not match.
- R5: An operand value write completes `WR_LAT` cycles after it is launched. It is launched at the clock edge that accepts the dispatch (for an operand present at dispatch) or at the edge that captures the broadcast. If the selector has room, the instruction appears on the issue outputs exactly `WR_LAT` cycles after the later of its two launch edges, and never earlier.
- R6: At most `ISS_W` slots are issued per cycle, chosen oldest first, in dispatch order. Issue lane 0 carries the oldest, and the valid issue lanes are always the lowest-numbered ones.
- R7: Each issued lane presents the dispatch ID of its instruction and the two operand values that were captured for it. Lane k uses bits `[k*ID_W +: ID_W]` of `iss_id` and `[k*DATA_W +: DATA_W]` of `iss_a` and `iss_b`.
- R8: `disp_stall` is high exactly when the number of valid dispatch lanes exceeds the number of free slots. In such a cycle no lane is accepted.
- R9: A slot that issues is not available to dispatch in the same cycle, and it is available in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | DISP_W | Dispatch lane valid, one bit per lane |
| disp_id | input | DISP_W*ID_W | Instruction ID per lane |
| disp_a_ok | input | DISP_W | Source A value supplied at dispatch |
| disp_a_tag | input | DISP_W*TAG_W | Source A producer tag |
| disp_a_val | input | DISP_W*DATA_W | Source A value when supplied |
| disp_b_ok | input | DISP_W | Source B value supplied at dispatch |
| disp_b_tag | input | DISP_W*TAG_W | Source B producer tag |
| disp_b_val | input | DISP_W*DATA_W | Source B value when supplied |
| disp_stall | output | 1 | Dispatch group refused this cycle |
| res_valid | input | BUS_W | Result bus valid, one bit per bus |
| res_tag | input | BUS_W*TAG_W | Result tag per bus |
| res_val | input | BUS_W*DATA_W | Result value per bus |
| iss_valid | output | ISS_W | Issue lane valid |
| iss_id | output | ISS_W*ID_W | Issued instruction ID |
| iss_a | output | ISS_W*DATA_W | Issued source A value |
| iss_b | output | ISS_W*DATA_W | Issued source B value |

## Verification
The bench builds the array with 8 slots, 2 result buses, 16-bit values, 6-bit tags and a write latency of 5. The dispatch and issue widths stay at 4. With only 8 slots, two dispatch groups fill the array, so the full-array stall, the partial-fit stall and the reuse of a slot freed one cycle earlier can all be reached within a few cycles. The short latency keeps each wake-up to issue window small. This lets the bench check the exact issue cycle and set up cycles in which more than four slots become eligible at once, which exercises the oldest-first choice.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int MASK_MAX = 64;

  // number of set bits in m strictly below position idx
  function automatic int cnt_below(input logic [MASK_MAX-1:0] m, input int idx);
    int n;
    n = 0;
    for (int i = 0; i < MASK_MAX; i++)
      if (i < idx && m[i]) n++;
    return n;
  endfunction

  // a countdown in its final beat commits the staged value
  function automatic logic last_beat(input int cnt);
    return cnt == 1;
  endfunction
endpackage

// File: rtl/rsw_alloc.sv
module rsw_alloc #(
  parameter int ENTRIES = 32,
  parameter int DISP_W  = 4,
  localparam int LANE_W = $clog2(DISP_W)
) (
  input  logic [ENTRIES-1:0]        free_mask,
  input  logic [DISP_W-1:0]         req,
  output logic                      stall,
  output logic [ENTRIES-1:0]        alloc,
  output logic [ENTRIES*LANE_W-1:0] ent_lane
);
  import rsw_pkg::*;

  int n_req, n_free;

  always_comb begin
    n_req  = $countones(req);
    n_free = $countones(free_mask);
    stall  = n_req > n_free;
    alloc  = '0;
    ent_lane = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (free_mask[e] && !stall) begin
        for (int k = 0; k < DISP_W; k++) begin
          if (req[k] && cnt_below(MASK_MAX'(req), k) == cnt_below(MASK_MAX'(free_mask), e)) begin
            alloc[e] = 1'b1;
            ent_lane[e*LANE_W +: LANE_W] = LANE_W'(k);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsw_status.sv
module rsw_status #(
  parameter int ENTRIES = 32,
  parameter int DISP_W  = 4,
  parameter int BUS_W   = 4,
  parameter int TAG_W   = 7,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 8,
  localparam int LANE_W = $clog2(DISP_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ENTRIES-1:0]          alloc,
  input  logic [ENTRIES*LANE_W-1:0]   ent_lane,
  input  logic [ENTRIES-1:0]          grant,
  input  logic [DISP_W*ID_W-1:0]      disp_id,
  input  logic [DISP_W-1:0]           disp_a_ok,
  input  logic [DISP_W*TAG_W-1:0]     disp_a_tag,
  input  logic [DISP_W*DATA_W-1:0]    disp_a_val,
  input  logic [DISP_W-1:0]           disp_b_ok,
  input  logic [DISP_W*TAG_W-1:0]     disp_b_tag,
  input  logic [DISP_W*DATA_W-1:0]    disp_b_val,
  input  logic [BUS_W-1:0]            res_valid,
  input  logic [BUS_W*TAG_W-1:0]      res_tag,
  input  logic [BUS_W*DATA_W-1:0]     res_val,
  output logic [ENTRIES-1:0]          ent_valid,
  output logic [ENTRIES-1:0]          ent_va,
  output logic [ENTRIES-1:0]          ent_vb,
  output logic [ENTRIES-1:0]          ent_rdy,
  output logic [ENTRIES*ENTRIES-1:0]  older,
  output logic [ENTRIES*ID_W-1:0]     ent_id,
  output logic [ENTRIES-1:0]          launch_a,
  output logic [ENTRIES-1:0]          launch_b,
  output logic [ENTRIES*DATA_W-1:0]   lval_a,
  output logic [ENTRIES*DATA_W-1:0]   lval_b
);
  logic [ENTRIES-1:0] valid_q, va_q, vb_q, rdy_q;
  logic [ENTRIES-1:0] valid_d, va_d, vb_d, rdy_d;
  logic [TAG_W-1:0]   tag_a_q [ENTRIES];
  logic [TAG_W-1:0]   tag_b_q [ENTRIES];
  logic [TAG_W-1:0]   tag_a_d [ENTRIES];
  logic [TAG_W-1:0]   tag_b_d [ENTRIES];
  logic [ID_W-1:0]    id_q    [ENTRIES];
  logic [ID_W-1:0]    id_d    [ENTRIES];
  logic [ENTRIES-1:0] old_q   [ENTRIES];
  logic [ENTRIES-1:0] old_d   [ENTRIES];

  // {hit, value} of the lowest-numbered bus carrying tag t
  function automatic logic [DATA_W:0] probe(input logic [TAG_W-1:0] t,
                                            input logic [BUS_W-1:0] bv,
                                            input logic [BUS_W*TAG_W-1:0] bt,
                                            input logic [BUS_W*DATA_W-1:0] bd);
    logic [DATA_W:0] r;
    r = '0;
    for (int b = BUS_W - 1; b >= 0; b--)
      if (bv[b] && bt[b*TAG_W +: TAG_W] == t) r = {1'b1, bd[b*DATA_W +: DATA_W]};
    return r;
  endfunction

  logic [LANE_W-1:0] ln, lj;
  logic [TAG_W-1:0]  ct_a, ct_b;
  logic              pd_a, pd_b, ok_a, ok_b;
  logic [DATA_W:0]   pr_a, pr_b;

  always_comb begin
    launch_a = '0;
    launch_b = '0;
    lval_a   = '0;
    lval_b   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      ln   = ent_lane[e*LANE_W +: LANE_W];
      ok_a = disp_a_ok[ln];
      ok_b = disp_b_ok[ln];
      ct_a = alloc[e] ? disp_a_tag[ln*TAG_W +: TAG_W] : tag_a_q[e];
      ct_b = alloc[e] ? disp_b_tag[ln*TAG_W +: TAG_W] : tag_b_q[e];
      pd_a = alloc[e] ? !ok_a : (valid_q[e] && !va_q[e]);
      pd_b = alloc[e] ? !ok_b : (valid_q[e] && !vb_q[e]);
      pr_a = probe(ct_a, res_valid, res_tag, res_val);
      pr_b = probe(ct_b, res_valid, res_tag, res_val);

      launch_a[e] = (alloc[e] && ok_a) || (pd_a && pr_a[DATA_W]);
      launch_b[e] = (alloc[e] && ok_b) || (pd_b && pr_b[DATA_W]);
      lval_a[e*DATA_W +: DATA_W] = (alloc[e] && ok_a) ? disp_a_val[ln*DATA_W +: DATA_W]
                                                      : pr_a[DATA_W-1:0];
      lval_b[e*DATA_W +: DATA_W] = (alloc[e] && ok_b) ? disp_b_val[ln*DATA_W +: DATA_W]
                                                      : pr_b[DATA_W-1:0];

      va_d[e]    = alloc[e] ? (ok_a || pr_a[DATA_W]) : (va_q[e] || (pd_a && pr_a[DATA_W]));
      vb_d[e]    = alloc[e] ? (ok_b || pr_b[DATA_W]) : (vb_q[e] || (pd_b && pr_b[DATA_W]));
      rdy_d[e]   = va_d[e] && vb_d[e];
      valid_d[e] = alloc[e] || (valid_q[e] && !grant[e]);
      tag_a_d[e] = ct_a;
      tag_b_d[e] = ct_b;
      id_d[e]    = alloc[e] ? disp_id[ln*ID_W +: ID_W] : id_q[e];

      // old_q[e][j] set: slot j holds an older instruction than slot e
      for (int j = 0; j < ENTRIES; j++) begin
        lj = ent_lane[j*LANE_W +: LANE_W];
        if (alloc[e])
          old_d[e][j] = valid_q[j] || (alloc[j] && lj < ln);
        else
          old_d[e][j] = alloc[j] ? 1'b0 : old_q[e][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      va_q    <= '0;
      vb_q    <= '0;
      rdy_q   <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_a_q[e] <= '0;
        tag_b_q[e] <= '0;
        id_q[e]    <= '0;
        old_q[e]   <= '0;
      end
    end else begin
      valid_q <= valid_d;
      va_q    <= va_d;
      vb_q    <= vb_d;
      rdy_q   <= rdy_d;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_a_q[e] <= tag_a_d[e];
        tag_b_q[e] <= tag_b_d[e];
        id_q[e]    <= id_d[e];
        old_q[e]   <= old_d[e];
      end
    end
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      older[e*ENTRIES +: ENTRIES] = old_q[e];
      ent_id[e*ID_W +: ID_W]      = id_q[e];
    end
  end

  assign ent_valid = valid_q;
  assign ent_va    = va_q;
  assign ent_vb    = vb_q;
  assign ent_rdy   = rdy_q;
endmodule

// File: rtl/rsw_slowdata.sv
module rsw_slowdata #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  parameter int WR_LAT  = 12,
  localparam int CNT_W  = $clog2(WR_LAT + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ENTRIES-1:0]        launch,
  input  logic [ENTRIES*DATA_W-1:0] wr_val,
  output logic [ENTRIES-1:0]        busy,
  output logic [ENTRIES*DATA_W-1:0] rd_val
);
  import rsw_pkg::*;

  logic [CNT_W-1:0]  cnt_q  [ENTRIES];
  logic [DATA_W-1:0] pend_q [ENTRIES];
  logic [DATA_W-1:0] cell_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) cnt_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (launch[e])            cnt_q[e] <= CNT_W'(WR_LAT);
        else if (cnt_q[e] != '0)  cnt_q[e] <= cnt_q[e] - 1'b1;
      end
    end
  end

  // staged value lands in the slow cell in the final countdown beat
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (launch[e]) pend_q[e] <= wr_val[e*DATA_W +: DATA_W];
      if (!launch[e] && last_beat(int'(cnt_q[e]))) cell_q[e] <= pend_q[e];
    end
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      busy[e] = cnt_q[e] != '0;
      rd_val[e*DATA_W +: DATA_W] = cell_q[e];
    end
  end
endmodule

// File: rtl/rsw_pick.sv
module rsw_pick #(
  parameter int ENTRIES = 32,
  parameter int ISS_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]         elig,
  input  logic [ENTRIES*ENTRIES-1:0] older,
  output logic [ENTRIES-1:0]         grant,
  output logic [ISS_W-1:0]           slot_vld,
  output logic [ISS_W*IDX_W-1:0]     slot_idx
);
  int rank;

  // rank of a slot = number of eligible slots older than it
  always_comb begin
    grant    = '0;
    slot_vld = '0;
    slot_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      rank = $countones(elig & older[e*ENTRIES +: ENTRIES]);
      for (int k = 0; k < ISS_W; k++) begin
        if (elig[e] && rank == k) begin
          grant[e]    = 1'b1;
          slot_vld[k] = 1'b1;
          slot_idx[k*IDX_W +: IDX_W] = IDX_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/rsw_window.sv
module rsw_window #(
  parameter int ENTRIES = 32,
  parameter int DISP_W  = 4,
  parameter int ISS_W   = 4,
  parameter int BUS_W   = 4,
  parameter int TAG_W   = 7,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 8,
  parameter int WR_LAT  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DISP_W-1:0]         disp_valid,
  input  logic [DISP_W*ID_W-1:0]    disp_id,
  input  logic [DISP_W-1:0]         disp_a_ok,
  input  logic [DISP_W*TAG_W-1:0]   disp_a_tag,
  input  logic [DISP_W*DATA_W-1:0]  disp_a_val,
  input  logic [DISP_W-1:0]         disp_b_ok,
  input  logic [DISP_W*TAG_W-1:0]   disp_b_tag,
  input  logic [DISP_W*DATA_W-1:0]  disp_b_val,
  output logic                      disp_stall,
  input  logic [BUS_W-1:0]          res_valid,
  input  logic [BUS_W*TAG_W-1:0]    res_tag,
  input  logic [BUS_W*DATA_W-1:0]   res_val,
  output logic [ISS_W-1:0]          iss_valid,
  output logic [ISS_W*ID_W-1:0]     iss_id,
  output logic [ISS_W*DATA_W-1:0]   iss_a,
  output logic [ISS_W*DATA_W-1:0]   iss_b
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int LANE_W = $clog2(DISP_W);

  // named internal events, also watched by the bound checker
  logic [ENTRIES-1:0]          ent_valid, ent_va, ent_vb, ent_rdy;
  logic [ENTRIES-1:0]          alloc, grant, elig, op_busy;
  logic [ENTRIES-1:0]          launch_a, launch_b, busy_a, busy_b;
  logic [ENTRIES*LANE_W-1:0]   ent_lane;
  logic [ENTRIES*ENTRIES-1:0]  older;
  logic [ENTRIES*ID_W-1:0]     ent_id;
  logic [ENTRIES*DATA_W-1:0]   lval_a, lval_b, cell_a, cell_b;
  logic [ISS_W*IDX_W-1:0]      slot_idx;

  rsw_alloc #(.ENTRIES(ENTRIES), .DISP_W(DISP_W)) u_alloc (
    .free_mask(~ent_valid), .req(disp_valid), .stall(disp_stall),
    .alloc(alloc), .ent_lane(ent_lane)
  );

  rsw_status #(.ENTRIES(ENTRIES), .DISP_W(DISP_W), .BUS_W(BUS_W), .TAG_W(TAG_W),
               .DATA_W(DATA_W), .ID_W(ID_W)) u_status (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .ent_lane(ent_lane), .grant(grant),
    .disp_id(disp_id),
    .disp_a_ok(disp_a_ok), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_ok(disp_b_ok), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val),
    .ent_valid(ent_valid), .ent_va(ent_va), .ent_vb(ent_vb), .ent_rdy(ent_rdy),
    .older(older), .ent_id(ent_id),
    .launch_a(launch_a), .launch_b(launch_b), .lval_a(lval_a), .lval_b(lval_b)
  );

  rsw_slowdata #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .WR_LAT(WR_LAT)) u_plane_a (
    .clk(clk), .rst_n(rst_n), .launch(launch_a), .wr_val(lval_a),
    .busy(busy_a), .rd_val(cell_a)
  );

  rsw_slowdata #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .WR_LAT(WR_LAT)) u_plane_b (
    .clk(clk), .rst_n(rst_n), .launch(launch_b), .wr_val(lval_b),
    .busy(busy_b), .rd_val(cell_b)
  );

  assign op_busy = busy_a | busy_b;
  assign elig    = ent_valid & ent_rdy & ~op_busy;

  rsw_pick #(.ENTRIES(ENTRIES), .ISS_W(ISS_W)) u_pick (
    .elig(elig), .older(older), .grant(grant),
    .slot_vld(iss_valid), .slot_idx(slot_idx)
  );

  logic [IDX_W-1:0] sx;

  always_comb begin
    iss_id = '0;
    iss_a  = '0;
    iss_b  = '0;
    for (int k = 0; k < ISS_W; k++) begin
      sx = slot_idx[k*IDX_W +: IDX_W];
      if (iss_valid[k]) begin
        iss_id[k*ID_W +: ID_W]     = ent_id[sx*ID_W +: ID_W];
        iss_a[k*DATA_W +: DATA_W]  = cell_a[sx*DATA_W +: DATA_W];
        iss_b[k*DATA_W +: DATA_W]  = cell_b[sx*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rsw_window_chk.sv
module rsw_window_chk #(
  parameter int ENTRIES = 32,
  parameter int DISP_W  = 4,
  parameter int ISS_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DISP_W-1:0]  disp_valid,
  input logic               disp_stall,
  input logic [ISS_W-1:0]   iss_valid,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_va,
  input logic [ENTRIES-1:0] ent_vb,
  input logic [ENTRIES-1:0] ent_rdy,
  input logic [ENTRIES-1:0] op_busy,
  input logic [ENTRIES-1:0] alloc,
  input logic [ENTRIES-1:0] grant
);
  logic [ISS_W-1:0] iss_inc;
  assign iss_inc = iss_valid + ISS_W'(1);

  assert_group_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_stall |-> $countones(alloc) == $countones(disp_valid));

  assert_ready_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rdy == (ent_va & ent_vb));

  assert_no_early_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & op_busy) == '0);

  assert_low_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_inc & iss_valid) == '0);

  assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == $countones(iss_valid));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> alloc == '0);

  assert_alloc_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc & ent_valid) == '0);

  assert_freed_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (ent_valid & $past(grant)) == '0);
endmodule

bind rsw_window rsw_window_chk #(.ENTRIES(ENTRIES), .DISP_W(DISP_W), .ISS_W(ISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_stall(disp_stall),
  .iss_valid(iss_valid), .ent_valid(ent_valid), .ent_va(ent_va), .ent_vb(ent_vb),
  .ent_rdy(ent_rdy), .op_busy(op_busy), .alloc(alloc), .grant(grant)
);

// File: tb/rsw_window_test.sv
`timescale 1ns/1ps
module rsw_window_test;
  localparam int N  = 8;
  localparam int DW = 4;
  localparam int IW = 4;
  localparam int BW = 2;
  localparam int TW = 6;
  localparam int VW = 16;
  localparam int XW = 8;
  localparam int L  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0]    disp_valid;
  logic [DW*XW-1:0] disp_id;
  logic [DW-1:0]    disp_a_ok, disp_b_ok;
  logic [DW*TW-1:0] disp_a_tag, disp_b_tag;
  logic [DW*VW-1:0] disp_a_val, disp_b_val;
  logic             disp_stall;
  logic [BW-1:0]    res_valid;
  logic [BW*TW-1:0] res_tag;
  logic [BW*VW-1:0] res_val;
  logic [IW-1:0]    iss_valid;
  logic [IW*XW-1:0] iss_id;
  logic [IW*VW-1:0] iss_a, iss_b;

  rsw_window #(.ENTRIES(N), .DISP_W(DW), .ISS_W(IW), .BUS_W(BW), .TAG_W(TW),
               .DATA_W(VW), .ID_W(XW), .WR_LAT(L)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_id(disp_id),
    .disp_a_ok(disp_a_ok), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_ok(disp_b_ok), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .disp_stall(disp_stall), .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_a(iss_a), .iss_b(iss_b)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { int id; int a; int b; int at; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic clear_in();
    disp_valid = '0; disp_id = '0;
    disp_a_ok = '0; disp_a_tag = '0; disp_a_val = '0;
    disp_b_ok = '0; disp_b_tag = '0; disp_b_val = '0;
    res_valid = '0; res_tag = '0; res_val = '0;
  endtask

  task automatic lane(input int k, input int id, input bit aok, input int at, input int av,
                      input bit bok, input int bt, input int bv);
    disp_valid[k] = 1'b1;
    disp_id[k*XW +: XW]    = XW'(id);
    disp_a_ok[k]           = aok;
    disp_a_tag[k*TW +: TW] = TW'(at);
    disp_a_val[k*VW +: VW] = VW'(av);
    disp_b_ok[k]           = bok;
    disp_b_tag[k*TW +: TW] = TW'(bt);
    disp_b_val[k*VW +: VW] = VW'(bv);
  endtask

  task automatic bcast(input int b, input int tag, input int val);
    res_valid[b] = 1'b1;
    res_tag[b*TW +: TW] = TW'(tag);
    res_val[b*VW +: VW] = VW'(val);
  endtask

  task automatic push(input int id, input int a, input int b, input int at);
    exp_t x;
    x.id = id; x.a = a; x.b = b; x.at = at;
    sb.push_back(x);
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected issues in order and compares them
  always @(negedge clk) begin : mon
    exp_t x;
    if (rst_n) begin
      for (int k = 0; k < IW; k++) begin
        if (iss_valid[k]) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R4 unexpected issue", iss_id[k*XW +: XW], -1);
          end else begin
            x = sb.pop_front();
            chk(int'(iss_id[k*XW +: XW]) == x.id, "R6 issue order id", iss_id[k*XW +: XW], x.id);
            chk(int'(iss_a[k*VW +: VW]) == x.a, "R7 operand a", iss_a[k*VW +: VW], x.a);
            chk(int'(iss_b[k*VW +: VW]) == x.b, "R7 operand b", iss_b[k*VW +: VW], x.b);
            if (x.at >= 0) chk(cyc == x.at, "R5 issue cycle", cyc, x.at);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int m;

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(iss_valid == '0, "R1 issue idle", iss_valid, 0);
    chk(disp_stall == 1'b0, "R1 no stall", disp_stall, 0);

    // R2/R5/R7: single ready instruction
    tick();
    lane(0, 1, 1, 0, 16'h1111, 1, 0, 16'h2222);
    push(1, 16'h1111, 16'h2222, cyc + 1 + L);
    tick();
    drain();

    // R2: sparse lanes, then a full group
    tick();
    lane(1, 2, 1, 0, 16'h0202, 1, 0, 16'h2020);
    lane(3, 3, 1, 0, 16'h0303, 1, 0, 16'h3030);
    push(2, 16'h0202, 16'h2020, cyc + 1 + L);
    push(3, 16'h0303, 16'h3030, cyc + 1 + L);
    tick();
    for (int k = 0; k < 4; k++) begin
      lane(k, 4 + k, 1, 0, 16'h0A00 + k, 1, 0, 16'h0B00 + k);
      push(4 + k, 16'h0A00 + k, 16'h0B00 + k, cyc + 1 + L);
    end
    tick();
    drain();

    // R4/R3: operand outstanding, wrong tag first, then match on bus 1
    tick();
    lane(0, 8, 0, 5, 0, 1, 0, 16'h0B0B);
    tick();
    bcast(0, 6, 16'h6666);
    repeat (8) tick();
    chk(iss_valid == '0, "R4 pending operand blocks issue", iss_valid, 0);
    bcast(0, 33, 16'h3333);
    bcast(1, 5, 16'h5555);
    push(8, 16'h5555, 16'h0B0B, cyc + 1 + L);
    tick();
    drain();

    // R3: capture in the dispatch cycle on both buses
    tick();
    lane(0, 9, 0, 12, 0, 0, 13, 0);
    bcast(0, 12, 16'hAAAA);
    bcast(1, 13, 16'hBBBB);
    push(9, 16'hAAAA, 16'hBBBB, cyc + 1 + L);
    tick();
    drain();

    // R6/R8/R9: fill array, wake all eight at once
    tick();
    for (int k = 0; k < 4; k++) lane(k, 20 + k, 0, 7, 0, 1, 0, 20 + k);
    tick();
    for (int k = 0; k < 4; k++) lane(k, 24 + k, 0, 8, 0, 1, 0, 24 + k);
    tick();
    lane(0, 99, 1, 0, 1, 1, 0, 1);
    #1 chk(disp_stall == 1'b1, "R8 full array stalls", disp_stall, 1);
    tick();
    m = cyc;
    bcast(0, 7, 16'h0707);
    bcast(1, 8, 16'h0808);
    for (int k = 0; k < 4; k++) push(20 + k, 16'h0707, 20 + k, m + 1 + L);
    for (int k = 0; k < 4; k++) push(24 + k, 16'h0808, 24 + k, m + 2 + L);
    tick();
    while (cyc < m + 1 + L) @(negedge clk);
    lane(0, 98, 1, 0, 1, 1, 0, 1);
    #1 chk(disp_stall == 1'b1, "R9 slot not free in issue cycle", disp_stall, 1);
    tick();
    for (int k = 0; k < 4; k++) begin
      lane(k, 30 + k, 1, 0, 16'h3000 + k, 1, 0, 16'h0300 + k);
      push(30 + k, 16'h3000 + k, 16'h0300 + k, cyc + 1 + L);
    end
    #1 chk(disp_stall == 1'b0, "R9 freed slots reused next cycle", disp_stall, 0);
    tick();
    drain();

    // R8: partial fit refused, exact fit accepted; R6 age across groups
    tick();
    for (int k = 0; k < 4; k++) lane(k, 40 + k, 0, 40, 0, 1, 0, 40 + k);
    tick();
    lane(0, 44, 0, 41, 0, 1, 0, 44);
    lane(1, 45, 0, 41, 0, 1, 0, 45);
    tick();
    lane(0, 97, 1, 0, 1, 1, 0, 1);
    lane(1, 96, 1, 0, 1, 1, 0, 1);
    lane(2, 95, 1, 0, 1, 1, 0, 1);
    #1 chk(disp_stall == 1'b1, "R8 three requests two free", disp_stall, 1);
    tick();
    lane(0, 46, 0, 42, 0, 1, 0, 46);
    lane(1, 47, 0, 42, 0, 1, 0, 47);
    #1 chk(disp_stall == 1'b0, "R8 two requests two free", disp_stall, 0);
    tick();
    m = cyc;
    bcast(0, 40, 16'h4040);
    bcast(1, 41, 16'h4141);
    for (int k = 0; k < 4; k++) push(40 + k, 16'h4040, 40 + k, m + 1 + L);
    push(44, 16'h4141, 44, m + 2 + L);
    push(45, 16'h4141, 45, m + 2 + L);
    push(46, 16'h4242, 46, m + 2 + L);
    push(47, 16'h4242, 47, m + 2 + L);
    tick();
    bcast(0, 42, 16'h4242);
    tick();
    drain();
    repeat (3) @(negedge clk);
    chk(iss_valid == '0, "R8 refused group never issues", iss_valid, 0);
    chk(sb.size() == 0, "R6 all expected issued", sb.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule